// File: doc/BRIEF.md
# Audio Clock Regeneration Packet Generator

This block builds the packet a digital video link uses to let the receiver rebuild its audio sample clock from the pixel clock. It holds an audio divisor N, taken from an input, and a cycle-time stamp CTS. CTS is either a constant supplied by the integrator or a live count of pixel clocks taken over N/128 audio sample periods. The block runs entirely in the pixel clock domain.

A free-running period counter raises a send request about once per millisecond. The request waits until the data-island scheduler signals a free packet slot. In that same cycle the block presents a header and four identical subpackets for the downstream encoder. Symbol encoding, error correction and island framing are handled by neighbouring logic. The scheduler may place another packet after this one in the same island.

A measured CTS follows the real ratio between the two clocks. Because of this, successive packets can differ by a few counts while N stays fixed. For example, a pixel clock near 33.835 MHz with 48 kHz audio and N = 6400 gives a CTS of about 35245.

Top module: `acr_packet_gen`

## Requirements
- R1: While reset is low, and after reset until a second interval boundary has been seen, the measured CTS is 0. The pkt_valid output is low during reset.
- R2: The header is HB0 = 0x01 (packet type), HB1 = 0x00 and HB2 = 0x00, with HB0 in pkt_header[7:0].
- R3: Each 56-bit subpacket holds bytes SB0..SB6, with SB k in bits [8k+7:8k]. SB0 = 0. SB1 = {4'h0, CTS[19:16]}. SB2 = CTS[15:8]. SB3 = CTS[7:0]. SB4 = {4'h0, N[19:16]}. SB5 = N[15:8]. SB6 = N[7:0].
- R4: The four subpackets, at pkt_sub bit offsets 0, 56, 112 and 168, are always identical.
- R5: With cts_measure low, the CTS field equals cts_fixed.
- R6: With cts_measure high, CTS equals the number of pixel clocks between two consecutive interval boundaries. A boundary is the audio_tick that completes a group of N[19:7] ticks.
- R7: A send request is raised every PERIOD_CLKS pixel clocks. With slot_ready held high, pkt_valid pulses exactly PERIOD_CLKS cycles apart.
- R8: pkt_valid is high only in a cycle where slot_ready is high, and then only if a request is pending.
- R9: A request that meets no free slot stays pending and is not dropped. Several requests that become due while no slot is free produce a single packet at the next free slot.
- R10: When N is below 128, each group is one audio tick long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| n_value | input | 20 | Audio divisor N |
| cts_fixed | input | 20 | Constant CTS used in fixed mode |
| cts_measure | input | 1 | 1 selects the measured CTS, 0 selects cts_fixed |
| audio_tick | input | 1 | One-cycle pulse per audio sample period |
| slot_ready | input | 1 | A packet slot is free in this cycle |
| pkt_valid | output | 1 | Packet is presented in this cycle |
| pkt_header | output | 24 | Header bytes HB2..HB0 |
| pkt_sub | output | 224 | Four identical 56-bit subpackets |

## Verification
The bench sets PERIOD_CLKS to 200. This makes the send period short enough to observe several packets, several interval boundaries and a multi-period stall within a few thousand cycles. The audio tick is driven at small periods between 3 and 13 clocks. Each N in the stimulus table then gives an exactly known CTS, and that includes N = 5632 and an N below 128. Holding the slot low for more than two periods lets the bench check that the stalled requests merge into one packet.

// File: rtl/acr_packet_gen.sv
module acr_packet_gen #(
  parameter int PERIOD_CLKS = 33835
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [19:0]  n_value,
  input  logic [19:0]  cts_fixed,
  input  logic         cts_measure,
  input  logic         audio_tick,
  input  logic         slot_ready,
  output logic         pkt_valid,
  output logic [23:0]  pkt_header,
  output logic [223:0] pkt_sub
);
  localparam int PW = $clog2(PERIOD_CLKS + 1);
  localparam logic [PW-1:0] PER_LAST = PW'(PERIOD_CLKS - 1);

  logic [PW-1:0] per_cnt;
  logic          pend;
  logic [12:0]   tick_cnt;
  logic [19:0]   pix_cnt;
  logic [19:0]   cts_meas;
  logic          meas_run;

  wire        due       = (per_cnt == PER_LAST);
  wire [12:0] ticks_req = (n_value[19:7] == 13'd0) ? 13'd1 : n_value[19:7];
  wire        boundary  = audio_tick && (({1'b0, tick_cnt} + 14'd1) >= {1'b0, ticks_req});
  wire [19:0] pix_next  = (pix_cnt == 20'hFFFFF) ? pix_cnt : pix_cnt + 20'd1;
  wire [19:0] cts_sel   = cts_measure ? cts_meas : cts_fixed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_cnt <= '0;
      pend    <= 1'b0;
    end else begin
      per_cnt <= due ? '0 : per_cnt + 1'b1;
      pend    <= due | (pend & ~slot_ready);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      pix_cnt  <= '0;
      cts_meas <= '0;
      meas_run <= 1'b0;
    end else begin
      if (audio_tick) tick_cnt <= boundary ? 13'd0 : tick_cnt + 13'd1;
      pix_cnt <= boundary ? 20'd0 : pix_next;
      if (boundary) begin
        meas_run <= 1'b1;
        if (meas_run) cts_meas <= pix_next;
      end
    end
  end

  wire [55:0] sub = {n_value[7:0], n_value[15:8], 4'h0, n_value[19:16],
                     cts_sel[7:0], cts_sel[15:8], 4'h0, cts_sel[19:16], 8'h00};

  assign pkt_valid  = pend & slot_ready;
  assign pkt_header = 24'h000001;

  for (genvar i = 0; i < 4; i++) begin : g_sub
    assign pkt_sub[56*i +: 56] = sub;
  end
endmodule

module acr_packet_gen_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         cts_measure,
  input logic [19:0]  cts_fixed,
  input logic         slot_ready,
  input logic         pkt_valid,
  input logic [223:0] pkt_sub
);
  always_comb begin
    if (!rst_n) assert_idle_in_reset_R1: assert (!pkt_valid);
  end

  assert_send_in_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> slot_ready);

  assert_copies_equal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (pkt_sub[55:0] == pkt_sub[111:56]) && (pkt_sub[55:0] == pkt_sub[167:112])
                  && (pkt_sub[55:0] == pkt_sub[223:168]));

  assert_pad_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (pkt_sub[7:0] == 8'h00) && (pkt_sub[15:12] == 4'h0) && (pkt_sub[39:36] == 4'h0));

  assert_fixed_cts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !cts_measure) |-> {pkt_sub[11:8], pkt_sub[23:16], pkt_sub[31:24]} == cts_fixed);
endmodule

bind acr_packet_gen acr_packet_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cts_measure(cts_measure), .cts_fixed(cts_fixed),
  .slot_ready(slot_ready), .pkt_valid(pkt_valid), .pkt_sub(pkt_sub)
);

// File: tb/test_acr_packet_gen.sv
module test_acr_packet_gen;
  localparam int PER = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [19:0] n_value = 20'd1024;
  logic [19:0] cts_fixed = 20'd0;
  logic cts_measure = 1'b1;
  logic audio_tick = 1'b0;
  logic slot_ready = 1'b1;
  logic pkt_valid;
  logic [23:0] pkt_header;
  logic [223:0] pkt_sub;

  int total = 0, bad = 0, tick_per = 255;
  bit done = 0;

  always #10 clk = ~clk;

  acr_packet_gen #(.PERIOD_CLKS(PER)) i_acr_packet_gen (
    .clk(clk), .rst_n(rst_n), .n_value(n_value), .cts_fixed(cts_fixed),
    .cts_measure(cts_measure), .audio_tick(audio_tick), .slot_ready(slot_ready),
    .pkt_valid(pkt_valid), .pkt_header(pkt_header), .pkt_sub(pkt_sub));

  // N, tick period, expected CTS
  localparam logic [47:0] VEC [0:4] = '{
    {20'd512,  8'd10, 20'd40},
    {20'd640,  8'd7,  20'd35},
    {20'd1024, 8'd3,  20'd24},
    {20'd100,  8'd13, 20'd13},
    {20'd5632, 8'd9,  20'd396}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic step;
    @(negedge clk);
    #5;
  endtask

  function automatic logic [19:0] get_cts(input logic [55:0] s);
    return {s[11:8], s[23:16], s[31:24]};
  endfunction
  function automatic logic [19:0] get_n(input logic [55:0] s);
    return {s[35:32], s[47:40], s[55:48]};
  endfunction

  task automatic wait_pkt;
    for (int i = 0; i < 2000; i++) begin
      step();
      if (pkt_valid) return;
    end
    check("R7 packet timeout", 0, 1);
  endtask

  task automatic check_pkt(input string req, input logic [19:0] en, input logic [19:0] ec);
    check({req, " R3 N"}, get_n(pkt_sub[55:0]), en);
    check({req, " CTS"}, get_cts(pkt_sub[55:0]), ec);
    check("R3 SB0 zero", pkt_sub[7:0], 0);
    check("R4 copy1", pkt_sub[111:56], pkt_sub[55:0]);
    check("R4 copy3", pkt_sub[223:168], pkt_sub[55:0]);
  endtask

  initial begin
    forever begin
      repeat (tick_per - 1) @(negedge clk);
      audio_tick = 1'b1;
      @(negedge clk);
      audio_tick = 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check("watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int gap;
    int pulses;
    repeat (4) step();
    check("R1 reset valid low", pkt_valid, 0);
    check("R2 header", pkt_header, 24'h000001);
    @(negedge clk); rst_n = 1'b1;
    wait_pkt();
    check_pkt("R1 initial measured", 20'd1024, 20'd0);
    check("R2 header type", pkt_header, 24'h000001);

    for (int v = 0; v < 5; v++) begin
      n_value = VEC[v][47:28];
      tick_per = int'(VEC[v][27:20]);
      repeat (1500) step();
      wait_pkt();
      check_pkt((v == 3) ? "R10 small N" : "R6 measured", VEC[v][47:28], VEC[v][19:0]);
    end

    cts_measure = 1'b0; cts_fixed = 20'd35245; n_value = 20'd6400;
    wait_pkt();
    check_pkt("R5 fixed", 20'd6400, 20'd35245);

    wait_pkt();
    gap = 0;
    do begin step(); gap++; end while (!pkt_valid && gap < 1000);
    check("R7 period", gap, PER);

    @(negedge clk); slot_ready = 1'b0;
    pulses = 0;
    for (int i = 0; i < 450; i++) begin
      step();
      if (pkt_valid) pulses++;
    end
    check("R8 no send without slot", pulses, 0);
    @(negedge clk); slot_ready = 1'b1; #5;
    check("R9 pending kept", pkt_valid, 1);
    step();
    check("R9 merged single packet", pkt_valid, 0);

    finish_run();
  end
endmodule